// File: doc/BRIEF.md
# Binary-Search Longest-Prefix Lookup Engine

This block resolves a 32-bit IPv4 destination address to a next-hop value. The forwarding table is a set of prefixes in which no prefix contains another, so at most one stored prefix can match any address, and that match is the longest one. The entries are kept in one single-port synchronous memory, sorted by their key. The key is the prefix value with every bit below the prefix length set to one.

A 256-slot range table is indexed by the top eight address bits. Each slot gives the first and last entry index worth searching for that address byte, or marks the slot as empty. After a request is accepted, the engine reads the slot and then bisects the window with one entry read per step. It stops on the first entry that matches, or when the window closes.

Software builds and sorts the table and loads it through the write port while the engine is idle. Only one lookup is in flight at a time.

Top module: `prefix_lookup`

## Requirements
- R1: After reset, req_ready and wr_ready are 1 and res_valid is 0.
- R2: When an entry whose index lies in the slot's window matches the address (the top len bits of the address equal the top len bits of the prefix), the result has res_hit=1 and res_nh equal to that entry's next hop.
- R3: When no entry in the window matches, the result has res_hit=0 and res_nh=0.
- R4: A slot whose empty flag is 1, or whose low index exceeds its high index, gives a miss with no entry read. If the request is accepted at edge n, res_valid is high after edge n+1.
- R5: Only entries whose index lies in [low, high] of slot req_addr[31:24] are considered. A matching entry outside that window yields a miss.
- R6: Each entry probe costs two cycles. With k reads, res_valid is high after edge n+1+2k, and k never exceeds ceil(log2(high-low+1))+1.
- R7: A request is taken on an edge where req_valid and req_ready are both 1. From the next cycle, req_ready and wr_ready stay 0 until the cycle in which res_valid is 1, and in that cycle wr_ready is 1 again.
- R8: A write is taken on an edge where wr_valid and wr_ready are both 1. A write raised during a lookup stalls until the result appears. In the idle state, a pending wr_valid forces req_ready to 0, so writes go first.
- R9: The write encoding is as follows. wr_sel=0 stores an entry at index wr_addr, holding wr_prefix, wr_len (0 to 32) and wr_nh. wr_sel=1 stores range slot wr_addr[7:0], holding wr_lo, wr_hi and wr_empty. Entries must be disjoint and written in ascending order of their padded key.
- R10: res_valid is high for exactly one cycle per lookup, and res_hit and res_nh are meaningful in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | 32 | Destination address to resolve |
| res_valid | output | 1 | Result present for one cycle |
| res_hit | output | 1 | A matching entry was found |
| res_nh | output | NH_W | Next hop of the match, zero on a miss |
| wr_valid | input | 1 | Table write present |
| wr_ready | output | 1 | Engine idle, write can be taken |
| wr_sel | input | 1 | 0 = entry memory, 1 = range slot |
| wr_addr | input | IDX_W | Entry index, or slot number in the low 8 bits |
| wr_prefix | input | 32 | Prefix value for an entry |
| wr_len | input | 6 | Prefix length for an entry |
| wr_nh | input | NH_W | Next hop for an entry |
| wr_lo | input | IDX_W | First entry index of a slot |
| wr_hi | input | IDX_W | Last entry index of a slot |
| wr_empty | input | 1 | Slot has no entries |

## Verification
The checker relies on three properties of the inputs. The table must be disjoint and sorted within every window. No slot window may extend past the loaded entries. req_valid must be dropped once a request has been taken. If any of these fails, the latency bound and the hit result lose their meaning.

The stimulus respects all three. It builds each slot out of eight sub-regions that do not overlap, with at most one prefix per region, written in region order. Every request is held only until the edge that takes it. Writes that overlap a lookup are the only ones the bench sends during a search, and they exercise the stall.

// File: rtl/pse_pkg.sv
package pse_pkg;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 6;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RANGE,
      ST_READ,
      ST_CMP
   } pse_state_t;

   function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
      logic [ADDR_W-1:0] m;
      if (len == '0)
         m = '0;
      else if (len >= LEN_W'(ADDR_W))
         m = '1;
      else
         m = ~({ADDR_W{1'b1}} >> len);
      return m;
   endfunction

   function automatic logic [ADDR_W-1:0] pad_key(input logic [ADDR_W-1:0] pfx,
                                                 input logic [LEN_W-1:0]  len);
      return pfx | ~len_mask(len);
   endfunction
endpackage

// File: rtl/pse_entry_mem.sv
module pse_entry_mem #(
   parameter int DEPTH = 1024,
   parameter int IDX_W = 16,
   parameter int W     = 46
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [IDX_W-1:0] addr,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0] store [DEPTH];
   logic         in_range;

   assign in_range = ({1'b0, addr} < (IDX_W+1)'(DEPTH));

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            if (in_range) store[addr[AW-1:0]] <= wdata;
         end else begin
            rdata <= in_range ? store[addr[AW-1:0]] : '0;
         end
      end
   end
endmodule

// File: rtl/pse_range_tab.sv
module pse_range_tab #(
   parameter int TOP_W = 8,
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             we,
   input  logic [TOP_W-1:0] waddr,
   input  logic [IDX_W-1:0] wlo,
   input  logic [IDX_W-1:0] whi,
   input  logic             wempty,
   input  logic [TOP_W-1:0] ridx,
   output logic [IDX_W-1:0] rlo,
   output logic [IDX_W-1:0] rhi,
   output logic             rempty
);
   localparam int SLOTS = 1 << TOP_W;
   localparam int SW    = 2*IDX_W + 1;

   logic [SW-1:0] slot [SLOTS];
   logic [SW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we) slot[waddr] <= {wempty, whi, wlo};
      rd_q <= slot[ridx];
   end

   assign rlo    = rd_q[IDX_W-1:0];
   assign rhi    = rd_q[2*IDX_W-1:IDX_W];
   assign rempty = rd_q[SW-1];
endmodule

// File: rtl/pse_ctrl.sv
module pse_ctrl
   import pse_pkg::*;
#(
   parameter int IDX_W = 16,
   parameter int NH_W  = 8,
   parameter int TOP_W = 8,
   localparam int W    = ADDR_W + LEN_W + NH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [TOP_W-1:0]  rng_idx,
   input  logic [IDX_W-1:0]  rng_lo,
   input  logic [IDX_W-1:0]  rng_hi,
   input  logic              rng_empty,
   output logic              mem_rd,
   output logic [IDX_W-1:0]  mid,
   input  logic [W-1:0]      mem_rdata,
   output logic              res_valid,
   output logic              res_hit,
   output logic [NH_W-1:0]   res_nh
);
   pse_state_t        state;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  lo, hi;
   logic [IDX_W:0]    span_sum;
   logic [ADDR_W-1:0] ent_key, ent_mask;
   logic [LEN_W-1:0]  ent_len;
   logic [NH_W-1:0]   ent_nh;
   logic              is_hit, go_low, accept;

   assign wr_ready  = (state == ST_IDLE);
   assign req_ready = wr_ready & ~wr_valid;
   assign accept    = req_valid & req_ready;
   assign rng_idx   = req_addr[ADDR_W-1 -: TOP_W];
   assign mem_rd    = (state == ST_READ);

   assign span_sum = {1'b0, lo} + {1'b0, hi};
   assign mid      = span_sum[IDX_W:1];

   assign ent_key  = mem_rdata[W-1 -: ADDR_W];
   assign ent_len  = mem_rdata[NH_W +: LEN_W];
   assign ent_nh   = mem_rdata[NH_W-1:0];
   assign ent_mask = len_mask(ent_len);
   assign is_hit   = ((addr_q ^ ent_key) & ent_mask) == '0;
   assign go_low   = addr_q < ent_key;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         lo        <= '0;
         hi        <= '0;
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_nh    <= '0;
      end else begin
         res_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= req_addr;
                  state  <= ST_RANGE;
               end
            end
            ST_RANGE: begin
               if (rng_empty || (rng_lo > rng_hi)) begin
                  res_valid <= 1'b1;
                  res_hit   <= 1'b0;
                  res_nh    <= '0;
                  state     <= ST_IDLE;
               end else begin
                  lo    <= rng_lo;
                  hi    <= rng_hi;
                  state <= ST_READ;
               end
            end
            ST_READ: state <= ST_CMP;
            ST_CMP: begin
               if (is_hit) begin
                  res_valid <= 1'b1;
                  res_hit   <= 1'b1;
                  res_nh    <= ent_nh;
                  state     <= ST_IDLE;
               end else if (go_low ? (mid == lo) : (mid == hi)) begin
                  res_valid <= 1'b1;
                  res_hit   <= 1'b0;
                  res_nh    <= '0;
                  state     <= ST_IDLE;
               end else begin
                  if (go_low) hi <= mid - 1'b1;
                  else        lo <= mid + 1'b1;
                  state <= ST_READ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/prefix_lookup.sv
module prefix_lookup
   import pse_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int IDX_W = 16,
   parameter int NH_W  = 8,
   parameter int TOP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [NH_W-1:0]   res_nh,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic              wr_sel,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [31:0]       wr_prefix,
   input  logic [5:0]        wr_len,
   input  logic [NH_W-1:0]   wr_nh,
   input  logic [IDX_W-1:0]  wr_lo,
   input  logic [IDX_W-1:0]  wr_hi,
   input  logic              wr_empty
);
   localparam int W = ADDR_W + LEN_W + NH_W;

   initial begin
      assert (IDX_W >= 16) else $error("IDX_W must be at least 16");
      assert (DEPTH >= 2 && DEPTH <= (1 << IDX_W)) else $error("DEPTH out of range");
      assert (TOP_W >= 1 && TOP_W <= 12) else $error("TOP_W out of range");
      assert (NH_W >= 1) else $error("NH_W must be positive");
   end

   logic [TOP_W-1:0] rng_idx;
   logic [IDX_W-1:0] rng_lo, rng_hi, mid, mem_addr;
   logic             rng_empty, mem_rd, wr_take, ent_we, rng_we;
   logic [W-1:0]     mem_rdata, mem_wdata;

   assign wr_take   = wr_valid & wr_ready;
   assign ent_we    = wr_take & ~wr_sel;
   assign rng_we    = wr_take &  wr_sel;
   assign mem_addr  = ent_we ? wr_addr : mid;
   assign mem_wdata = {pad_key(wr_prefix, wr_len), wr_len, wr_nh};

   pse_range_tab #(.TOP_W(TOP_W), .IDX_W(IDX_W)) u_range (
      .clk    (clk),
      .we     (rng_we),
      .waddr  (wr_addr[TOP_W-1:0]),
      .wlo    (wr_lo),
      .whi    (wr_hi),
      .wempty (wr_empty),
      .ridx   (rng_idx),
      .rlo    (rng_lo),
      .rhi    (rng_hi),
      .rempty (rng_empty)
   );

   pse_entry_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(W)) u_mem (
      .clk   (clk),
      .en    (ent_we | mem_rd),
      .we    (ent_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   pse_ctrl #(.IDX_W(IDX_W), .NH_W(NH_W), .TOP_W(TOP_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .rng_idx   (rng_idx),
      .rng_lo    (rng_lo),
      .rng_hi    (rng_hi),
      .rng_empty (rng_empty),
      .mem_rd    (mem_rd),
      .mid       (mid),
      .mem_rdata (mem_rdata),
      .res_valid (res_valid),
      .res_hit   (res_hit),
      .res_nh    (res_nh)
   );
endmodule

// File: rtl/pse_checker.sv
module pse_checker #(
   parameter int IDX_W = 16,
   parameter int NH_W  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            wr_ready,
   input logic            res_valid,
   input logic            res_hit,
   input logic [NH_W-1:0] res_nh
);
   localparam int MAX_LAT = 2 * (IDX_W + 1) + 1;
   localparam int CW      = $clog2(MAX_LAT + 2) + 1;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         busy_cnt <= '0;
      else if (wr_ready)                  busy_cnt <= '0;
      else if (busy_cnt != {CW{1'b1}})    busy_cnt <= busy_cnt + 1'b1;
   end

   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !res_valid));

   assert_idle_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> wr_ready);

   assert_write_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !wr_ready);

   assert_miss_no_hop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_nh == '0));

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_latency_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CW'(MAX_LAT));
endmodule

bind prefix_lookup pse_checker #(.IDX_W(IDX_W), .NH_W(NH_W)) u_pse_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .wr_ready  (wr_ready),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_nh    (res_nh)
);

// File: tb/prefix_lookup_test.sv
`timescale 1ns/100ps
module prefix_lookup_test;
   localparam int IDX_W = 16;
   localparam int NH_W  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [31:0]      req_addr = '0;
   logic             res_valid, res_hit;
   logic [NH_W-1:0]  res_nh;
   logic             wr_valid = 1'b0;
   logic             wr_ready;
   logic             wr_sel = 1'b0;
   logic [IDX_W-1:0] wr_addr = '0;
   logic [31:0]      wr_prefix = '0;
   logic [5:0]       wr_len = '0;
   logic [NH_W-1:0]  wr_nh = '0;
   logic [IDX_W-1:0] wr_lo = '0, wr_hi = '0;
   logic             wr_empty = 1'b0;

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   int unsigned m_pfx [1024];
   int          m_len [1024];
   int          m_nh  [1024];
   int          r_lo [256];
   int          r_hi [256];
   bit          r_empty [256];

   always #2.5 clk = ~clk;

   prefix_lookup #(.DEPTH(1024), .IDX_W(IDX_W), .NH_W(NH_W), .TOP_W(8)) uut (.*);

   function automatic int unsigned msk(input int l);
      if (l <= 0) return 32'h0;
      if (l >= 32) return 32'hFFFF_FFFF;
      return ~(32'hFFFF_FFFF >> l);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_write(input bit sel, input int idx, input int unsigned pfx,
                           input int len, input int nh, input int lo, input int hi,
                           input bit emp, output int stalls);
      stalls = 0;
      wr_sel = sel; wr_addr = IDX_W'(idx); wr_prefix = pfx; wr_len = 6'(len);
      wr_nh = NH_W'(nh); wr_lo = IDX_W'(lo); wr_hi = IDX_W'(hi); wr_empty = emp;
      wr_valid = 1'b1;
      #1;
      while (!wr_ready) begin
         stalls++;
         @(negedge clk); #1;
      end
      @(negedge clk);
      wr_valid = 1'b0;
      if (sel) begin
         r_lo[idx & 255] = lo; r_hi[idx & 255] = hi; r_empty[idx & 255] = emp;
      end else begin
         m_pfx[idx] = pfx & msk(len); m_len[idx] = len; m_nh[idx] = nh;
      end
   endtask

   task automatic put_entry(input int idx, input int unsigned pfx, input int len, input int nh);
      int s;
      do_write(1'b0, idx, pfx, len, nh, 0, 0, 1'b0, s);
   endtask

   task automatic put_range(input int slot, input int lo, input int hi, input bit emp);
      int s;
      do_write(1'b1, slot, 0, 0, 0, lo, hi, emp, s);
   endtask

   task automatic lookup(input int unsigned a, input string tag);
      int  slot = int'(a >> 24);
      bit  e_hit = 1'b0;
      int  e_nh = 0;
      bit  no_win;
      int  n, bound, cnt, k;
      bit  busy_ok = 1'b1;
      no_win = r_empty[slot] || (r_lo[slot] > r_hi[slot]);
      if (!no_win)
         for (int j = r_lo[slot]; j <= r_hi[slot]; j++)
            if (((a ^ m_pfx[j]) & msk(m_len[j])) == 0) begin
               e_hit = 1'b1; e_nh = m_nh[j];
            end
      req_addr = a; req_valid = 1'b1;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      cnt = 1;
      while (!res_valid && cnt < 200) begin
         if (req_ready || wr_ready) busy_ok = 1'b0;
         @(negedge clk);
         cnt++;
      end
      chk(busy_ok, "R7", {tag, " ready low while busy"}, busy_ok, 1);
      chk(wr_ready == 1'b1, "R7", {tag, " idle at result"}, wr_ready, 1);
      chk(res_hit == e_hit, e_hit ? "R2" : "R3", {tag, " hit"}, res_hit, e_hit);
      chk(res_nh == NH_W'(e_nh), e_hit ? "R2" : "R3", {tag, " next hop"}, res_nh, e_nh);
      k = (cnt - 2) / 2;
      if (no_win) begin
         chk(cnt == 2, "R4", {tag, " empty-slot latency"}, cnt, 2);
      end else begin
         n = r_hi[slot] - r_lo[slot] + 1;
         bound = $clog2(n) + 1;
         chk((cnt % 2 == 0) && k >= 1 && k <= bound, "R6", {tag, " probe count"}, k, bound);
      end
      @(negedge clk);
      chk(res_valid == 1'b0, "R10", {tag, " result pulse width"}, res_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      int nxt;
      int stl;
      int unsigned pf, ad;
      int first, b, len;
      for (int i = 0; i < 1024; i++) begin m_pfx[i] = 0; m_len[i] = 32; m_nh[i] = 0; end
      for (int i = 0; i < 256; i++) begin r_lo[i] = 0; r_hi[i] = 0; r_empty[i] = 1'b1; end

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
      chk(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
      chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && wr_ready && !res_valid, "R1", "idle after reset",
          {req_ready, wr_ready, res_valid}, 3'b110);

      for (int i = 0; i < 256; i++) put_range(i, 0, 0, 1'b1);

      // random slots built from eight non-overlapping sub-regions each (R9)
      nxt = 0;
      for (int s = 0; s < 16; s++) begin
         b = 16 + s * 13;
         first = nxt;
         if (s == 1) begin
            put_entry(nxt, b << 24, 8, 100); nxt++;
         end else if (s != 0) begin
            for (int r = 0; r < 8; r++) begin
               if ($urandom % 4 != 0) begin
                  len = 11 + int'($urandom % 22);
                  pf  = (b << 24) | (r << 21) | ($urandom & 32'h001F_FFFF);
                  put_entry(nxt, pf, len, 1 + int'($urandom % 250)); nxt++;
               end
            end
         end
         if (nxt > first) put_range(b, first, nxt - 1, 1'b0);
      end

      for (int s = 0; s < 16; s++) begin
         b = 16 + s * 13;
         if (!r_empty[b])
            for (int j = r_lo[b]; j <= r_hi[b]; j++)
               lookup(m_pfx[j] | ($urandom & ~msk(m_len[j])), "random hit");
         for (int t = 0; t < 3; t++)
            lookup((b << 24) | ($urandom & 32'h00FF_FFFF), "random probe");
      end
      lookup(32'h0501_0203, "never-written slot");
      lookup(32'h1000_0000, "empty slot");

      // fixed slot 200: three /16 entries at 900..902
      put_entry(900, 32'hC800_0000, 16, 11);
      put_entry(901, 32'hC801_0000, 16, 12);
      put_entry(902, 32'hC802_0000, 16, 13);
      put_range(200, 900, 902, 1'b0);
      lookup(32'hC802_0505, "R9 fixed table last entry");
      lookup(32'hC800_FFFF, "R9 fixed table first entry");
      lookup(32'hC803_0000, "fixed table gap");

      // low > high with empty flag clear
      put_range(201, 5, 4, 1'b0);
      lookup(32'hC900_0000, "R4 inverted window");

      // idle write has priority over a request (R8)
      wr_sel = 1'b1; wr_addr = IDX_W'(202); wr_lo = '0; wr_hi = '0; wr_empty = 1'b1;
      wr_valid = 1'b1; req_valid = 1'b1; req_addr = 32'hCA00_0000;
      #1;
      chk(req_ready == 1'b0, "R8", "req_ready with write pending", req_ready, 0);
      chk(wr_ready == 1'b1, "R8", "wr_ready when idle", wr_ready, 1);
      @(negedge clk);
      wr_valid = 1'b0; req_valid = 1'b0;
      r_lo[202] = 0; r_hi[202] = 0; r_empty[202] = 1'b1;

      // write raised mid-lookup stalls; the lookup uses the old window (R8, R5)
      fork
         lookup(32'hC802_0505, "R8 lookup during stalled write");
         begin
            @(negedge clk);
            do_write(1'b1, 200, 0, 0, 0, 900, 901, 1'b0, stl);
            chk(stl >= 2, "R8", "write stall cycles", stl, 2);
         end
      join
      lookup(32'hC802_0505, "R5 match outside narrowed window");
      lookup(32'hC801_0101, "R5 match inside narrowed window");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule